// File: doc/BRIEF.md
# Ramped Digital Attenuator with Soft Mute

This block scales a stream of 24-bit two's-complement audio samples by a gain chosen with a 7-bit attenuation code. Code 0 passes samples unchanged, code 127 silences them, and every code in between applies a gain of (127 − code)/128. A new code never takes effect at once. The applied code walks toward the requested one, a single code step at a time, and each step waits for a fixed number of sample strobes. The number of strobes per step depends on a rate-mode input. This avoids audible clicks when the volume changes.

A mute input, active low, drives the applied code toward full attenuation at the same step rate. When mute is released, the applied code walks back to the stored target. A code written while mute is active is only stored. It is applied, by ramping, once mute is released. The block sits in the sample path between a filter stage and the output formatter. Each accepted sample produces one scaled sample one clock later.

Top module: `soft_gain_atten`

## Requirements
- R1: When the applied code is 0, the scaled output equals the input sample exactly, including the full-scale values +8388607 and −8388608.
- R2: When the applied code D is between 1 and 126, the output equals floor(sample × (127 − D) / 128), rounded toward negative infinity. For example, with D = 64 an input of 4194304 gives 2064384 and an input of −1 gives −1.
- R3: When the applied code is 127, the output is 0 for every input.
- R4: After reset, the stored target and the applied code are both 0, out_valid is 0 and out_sample is 0.
- R5: out_valid is high in exactly the cycle after each in_valid strobe, and out_sample holds its value in cycles without a strobe. Each strobe's output uses the applied code as it stood at that strobe.
- R6: With rate_hi = 0, the applied code changes by exactly one toward its goal after every 8th strobe counted while it differs from the goal. A full sweep from 0 to 127 therefore takes 1016 strobes, and the applied code never changes in a cycle without a strobe.
- R7: With rate_hi = 1, each step takes 16 strobes, so a full sweep takes 2032 strobes.
- R8: While mute_n is 0, the goal is code 127. When mute_n returns to 1, the applied code ramps back to the stored target at the same step rate.
- R9: A code written while mute_n is 0 only updates the stored target. The output stays silent until mute is released.
- R10: If the target changes during a ramp, the ramp continues from the current applied code toward the new target, without restarting the strobe count.
- R11: The strobe counter clears whenever the applied code equals its goal. After a new target is written to an idle block, the first step happens after the 8th strobe (normal rate), so the 9th strobe sees the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one cycle per input sample |
| in_sample | input | 24 | Input sample, two's complement |
| rate_hi | input | 1 | 0: 8 strobes per step, 1: 16 strobes per step |
| mute_n | input | 1 | Active-low soft mute |
| wr_en | input | 1 | Write strobe for the target code |
| wr_code | input | 7 | Target attenuation code written on wr_en |
| out_valid | output | 1 | Scaled sample valid, one cycle after in_valid |
| out_sample | output | 24 | Scaled sample, two's complement |

## Verification
The properties assume that in_valid is a single-cycle strobe sampled on the clock. They also assume that rate_hi changes only while the applied code is at its goal, and that reset is asserted before the first clock edge. The stimulus holds reset low from time zero and releases it on a falling edge. It pulses in_valid for one cycle at a time, with idle gaps of zero or one cycle, and it changes rate_hi only together with a target write on an idle ramp. Every clock, a behavioural model in the bench follows the target, goal and step count, and it predicts each output from the rule in the requirements.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W   = 7;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/atten_target.sv
// Holds the software target and derives the goal seen by the ramp.
module atten_target
  import atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  code_t wr_code,
  input  logic  mute_n,
  output code_t target_code,
  output code_t goal_code
);
  code_t target_q;
  code_t target_d;

  always_comb begin
    target_d = target_q;
    if (wr_en) target_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) target_q <= '0;
    else        target_q <= target_d;
  end

  // Mute overrides the goal but never touches the stored target.
  assign goal_code   = mute_n ? target_q : code_t'(CODE_MAX);
  assign target_code = target_q;
endmodule

// File: rtl/atten_step_timer.sv
// Counts sample strobes while a ramp is pending and fires one step per period.
module atten_step_timer #(
  parameter int STEP_NORM = 8,
  parameter int STEP_HIGH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic rate_hi,
  input  logic at_goal,
  output logic step_fire
);
  localparam int STEP_MAX = (STEP_HIGH > STEP_NORM) ? STEP_HIGH : STEP_NORM;
  localparam int CNT_W    = (STEP_MAX > 2) ? $clog2(STEP_MAX) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_cnt;
  logic             cnt_en;

  assign last_cnt  = rate_hi ? CNT_W'(STEP_HIGH - 1) : CNT_W'(STEP_NORM - 1);
  assign cnt_en    = at_goal || in_valid;
  // A count left above the limit by a rate change fires on the next strobe.
  assign step_fire = in_valid && !at_goal && (cnt_q >= last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (at_goal)        cnt_d = '0;
    else if (step_fire) cnt_d = '0;
    else if (in_valid)  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/atten_ramp.sv
// Applied code register that walks one code per step toward the goal.
module atten_ramp
  import atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t goal_code,
  input  logic  step_fire,
  output code_t applied_code,
  output logic  at_goal
);
  code_t     applied_q;
  code_t     applied_d;
  ramp_dir_e dir;

  always_comb begin
    if (goal_code > applied_q)      dir = RAMP_UP;
    else if (goal_code < applied_q) dir = RAMP_DOWN;
    else                            dir = RAMP_HOLD;
  end

  always_comb begin
    applied_d = applied_q;
    if (step_fire) begin
      case (dir)
        RAMP_UP:   applied_d = applied_q + code_t'(1);
        RAMP_DOWN: applied_d = applied_q - code_t'(1);
        default:   applied_d = applied_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         applied_q <= '0;
    else if (step_fire) applied_q <= applied_d;
  end

  assign applied_code = applied_q;
  assign at_goal      = (dir == RAMP_HOLD);
endmodule

// File: rtl/atten_scaler.sv
// Multiplies a sample by (CODE_MAX - code)/2^CODE_W, with unity and zero bypasses.
module atten_scaler
  import atten_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  code_t               code,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  localparam int GAIN_W = CODE_W + 1;
  localparam int PROD_W = SAMPLE_W + GAIN_W;

  logic [GAIN_W-1:0]          gain_num;
  logic signed [PROD_W-1:0]   prod;
  logic [SAMPLE_W-1:0]        scaled;
  logic                       valid_q;
  logic [SAMPLE_W-1:0]        sample_q;
  logic [SAMPLE_W-1:0]        sample_d;

  assign gain_num = GAIN_W'(CODE_MAX) - {1'b0, code};
  assign prod     = $signed(in_sample) * $signed(gain_num);

  always_comb begin
    if (code == '0)                    scaled = in_sample;
    else if (code == code_t'(CODE_MAX)) scaled = '0;
    else                               scaled = SAMPLE_W'(prod >>> CODE_W);
  end

  always_comb begin
    sample_d = sample_q;
    if (in_valid) sample_d = scaled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q  <= in_valid;
      sample_q <= sample_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_sample = sample_q;
endmodule

// File: rtl/soft_gain_atten.sv
module soft_gain_atten
  import atten_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int STEP_NORM = 8,
  parameter int STEP_HIGH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                rate_hi,
  input  logic                mute_n,
  input  logic                wr_en,
  input  logic [CODE_W-1:0]   wr_code,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  code_t target_code;
  code_t goal_code;
  code_t applied_code;
  logic  at_goal;
  logic  step_fire;

  atten_target u_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_code     (wr_code),
    .mute_n      (mute_n),
    .target_code (target_code),
    .goal_code   (goal_code)
  );

  atten_step_timer #(
    .STEP_NORM (STEP_NORM),
    .STEP_HIGH (STEP_HIGH)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rate_hi   (rate_hi),
    .at_goal   (at_goal),
    .step_fire (step_fire)
  );

  atten_ramp u_ramp (
    .clk          (clk),
    .rst_n        (rst_n),
    .goal_code    (goal_code),
    .step_fire    (step_fire),
    .applied_code (applied_code),
    .at_goal      (at_goal)
  );

  atten_scaler #(
    .SAMPLE_W (SAMPLE_W)
  ) u_scaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .code       (applied_code),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );
endmodule

// File: rtl/atten_chk.sv
module atten_chk
  import atten_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                mute_n,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_sample,
  input code_t               applied_code
);
  // R5
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R5
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample)));

  // R1
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && applied_code == '0) |=> (out_sample == $past(in_sample)));

  // R3
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && applied_code == code_t'(CODE_MAX)) |=> (out_sample == '0));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (applied_code != $past(applied_code)) |->
      (({1'b0, applied_code} == {1'b0, $past(applied_code)} + 8'd1) ||
       ({1'b0, applied_code} + 8'd1 == {1'b0, $past(applied_code)})));

  // R6
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(applied_code));

  // R8
  mute_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |=> (applied_code >= $past(applied_code)));
endmodule

bind soft_gain_atten atten_chk #(.SAMPLE_W(SAMPLE_W)) u_atten_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_sample    (in_sample),
  .mute_n       (mute_n),
  .out_valid    (out_valid),
  .out_sample   (out_sample),
  .applied_code (applied_code)
);

// File: tb/tb_soft_gain_atten.sv
`timescale 1ns/1ps
module tb_soft_gain_atten;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_sample;
  logic        rate_hi;
  logic        mute_n;
  logic        wr_en;
  logic [6:0]  wr_code;
  logic        out_valid;
  logic [23:0] out_sample;

  int    checks = 0;
  int    errors = 0;
  string req_tag = "R4";
  bit    cmp_on = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  // behavioural reference state
  int m_tgt, m_cur, m_cnt, exp_s;
  bit exp_v;

  always #4 clk = ~clk;

  soft_gain_atten dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .rate_hi(rate_hi), .mute_n(mute_n), .wr_en(wr_en), .wr_code(wr_code),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic int gain_of(int s, int c);
    longint p, r;
    if (c == 0)   return s;
    if (c == 127) return 0;
    p = longint'(s) * longint'(127 - c);
    r = p % 128;
    if (r < 0) r = r + 128;
    return int'((p - r) / 128);
  endfunction

  always @(posedge clk) begin
    int goal;
    int per;
    if (!rst_n) begin
      m_tgt = 0; m_cur = 0; m_cnt = 0; exp_v = 0; exp_s = 0;
    end else begin
      goal = mute_n ? m_tgt : 127;
      per  = rate_hi ? 16 : 8;
      exp_v = in_valid;
      if (in_valid) exp_s = gain_of($signed(in_sample), m_cur);
      if (m_cur == goal) m_cnt = 0;
      else if (in_valid) begin
        if (m_cnt >= per - 1) begin
          m_cur = (goal > m_cur) ? m_cur + 1 : m_cur - 1;
          m_cnt = 0;
        end else m_cnt = m_cnt + 1;
      end
      if (wr_en) m_tgt = int'(wr_code);
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(req_tag, int'(out_valid), int'(exp_v));
      chk(req_tag, $signed(out_sample), exp_s);
    end
  end

  task automatic send(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      in_valid  = 1'b1;
      in_sample = lcg[30:7];
      if (i % 4 == 1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic probe(int s, int e, string r);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s[23:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk(r, $signed(out_sample), e);
  endtask

  task automatic write_code(int c);
    @(negedge clk);
    wr_en = 1'b1;
    wr_code = c[6:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; rate_hi = 1'b0;
    mute_n = 1'b1; wr_en = 1'b0; wr_code = '0;
    repeat (3) @(negedge clk);
    // R4: reset state
    chk("R4", int'(out_valid), 0);
    chk("R4", $signed(out_sample), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1: unity at code 0
    req_tag = "R1";
    send(20);
    probe(8388607, 8388607, "R1");
    probe(-8388608, -8388608, "R1");

    // R6: ramp to 64 at normal rate, R2 values
    req_tag = "R6";
    write_code(64);
    send(520);
    req_tag = "R2";
    probe(4194304, 2064384, "R2");
    probe(-4194304, -2064384, "R2");
    probe(-1, -1, "R2");

    // R11: idle timer cleared, first step after 8th strobe
    req_tag = "R11";
    write_code(65);
    for (int i = 0; i < 8; i++) probe(4194304, 2064384, "R11");
    probe(4194304, 2031616, "R11");

    // R10: target changed mid-ramp
    req_tag = "R10";
    write_code(100);
    send(100);
    write_code(90);
    send(220);
    probe(4194304, 1212416, "R10");

    // R3: full attenuation
    req_tag = "R3";
    write_code(127);
    send(300);
    probe(8388607, 0, "R3");
    probe(-8388608, 0, "R3");

    // R7: high rate, 16 strobes per step
    req_tag = "R7";
    @(negedge clk);
    rate_hi = 1'b1;
    write_code(0);
    for (int i = 0; i < 16; i++) probe(4194304, 0, "R7");
    probe(4194304, 32768, "R7");
    send(2040);
    probe(-8388608, -8388608, "R7");

    // R8 / R9: mute ramp, write during mute, release
    req_tag = "R8";
    @(negedge clk);
    rate_hi = 1'b0;
    mute_n  = 1'b0;
    send(1020);
    probe(4194304, 0, "R8");
    req_tag = "R9";
    write_code(50);
    send(200);
    probe(8388607, 0, "R9");
    req_tag = "R8";
    @(negedge clk);
    mute_n = 1'b1;
    send(630);
    probe(4194304, 2523136, "R8");

    // R5: output holds when idle
    req_tag = "R5";
    repeat (5) @(negedge clk);
    chk("R5", int'(out_valid), 0);
    chk("R5", $signed(out_sample), 2523136);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule